// File: doc/BRIEF.md
# Single-Line Interrupt Trigger Controller

This block conditions one asynchronous interrupt wire for a parent interrupt controller. The wire is brought into the clock domain through a synchroniser. It is then judged against a programmable trigger condition: low level, high level, falling edge or rising edge. Qualifying events set a sticky pending flag. The flag is ANDed with an enable bit, and the result is registered to form the interrupt output.

Software reaches three registers over a plain 32-bit register port that has an address, a write strobe with data, and a read strobe. The port has no handshake. A write completes on the clock edge where the strobe is high. Read data is valid in the same cycle as the read strobe and is zero whenever the strobe is low. A build-time layout parameter selects one of three address maps for the registers.

Top module: `irq_trig_ctrl`

## Requirements
- R1: The trigger mode is bits [1:0] of the control register. 0 = low level, 1 = falling edge, 2 = high level, 3 = rising edge. The mode after reset is 0 (low level).
- R2: The control register stores and returns all 32 written bits. Only bits [1:0] affect behaviour.
- R3: In an edge mode, a detected edge sets pending, and pending stays set until software clears it. When an edge and a clear fall in the same cycle, pending ends up set.
- R4: In a level mode, pending is set on every cycle that the synchronised input is at the active level. A clear therefore only sticks once the input has gone inactive.
- R5: Writing 1 to bit 0 of the pending register clears pending. Writing 0 to that bit leaves pending unchanged. Reads return pending in bit 0 and zeros in all other bits.
- R6: The interrupt output equals pending AND enable, as they stood one cycle earlier. Enable is bit 0 of the enable register. Pending still records events while enable is 0.
- R7: LAYOUT 0 maps control at 0x00, pending at 0x04 and enable at 0x08. LAYOUT 1 maps control at 0x00, pending at 0x04 and enable at 0x34. LAYOUT 2 maps control at 0x00, enable at 0x04 and pending at 0x08.
- R8: A read of an unmapped offset returns 0, and a write to an unmapped offset changes nothing. Read data is 0 when the read strobe is low.
- R9: Reset clears the control, enable and pending state and the interrupt output.
- R10: An input change reaches the detector after two synchroniser flops. A rising edge driven just after a clock edge shows up in pending after the third clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 1 | Raw asynchronous interrupt wire |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wr | input | 1 | Write strobe, one write per high cycle |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, valid while bus_rd is high |
| irq_out | output | 1 | Masked interrupt toward the parent controller |

## Verification
The trigger logic is first driven with directed patterns:
- A single clean rising step measures the synchroniser latency.
- A step on the inactive polarity shows that edge modes ignore the wrong direction.
- A held active level with a clear in progress separates level behaviour from edge behaviour.
- An edge that coincides with a clear exposes the set-over-clear priority.

After these, random input toggling mixed with random register traffic, including unmapped offsets and pending writes with bit 0 both set and cleared, is compared against a bench reference every cycle. This distinguishes mask timing from pending retention. The two other address layouts get directed accesses that tell apart which offset holds enable, which holds pending, and which is unmapped.

// File: rtl/irq_trig_pkg.sv
package irq_trig_pkg;

  typedef enum logic [1:0] {
    TRIG_LVL_LO    = 2'd0,
    TRIG_EDGE_FALL = 2'd1,
    TRIG_LVL_HI    = 2'd2,
    TRIG_EDGE_RISE = 2'd3
  } trig_mode_e;

  // Byte offsets of the three registers for each address layout.
  function automatic int unsigned ctrl_off(input int unsigned layout);
    ctrl_off = 0;
    if (layout > 2) ctrl_off = 0;
  endfunction

  function automatic int unsigned pend_off(input int unsigned layout);
    case (layout)
      2:       pend_off = 8;
      default: pend_off = 4;
    endcase
  endfunction

  function automatic int unsigned en_off(input int unsigned layout);
    case (layout)
      1:       en_off = 52;
      2:       en_off = 4;
      default: en_off = 8;
    endcase
  endfunction

  function automatic logic is_edge(input trig_mode_e m);
    is_edge = (m == TRIG_EDGE_FALL) || (m == TRIG_EDGE_RISE);
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/irq_trig_detect.sv
module irq_trig_detect
  import irq_trig_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lvl,
  input  trig_mode_e mode,
  output logic       evt
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl;
  end

  always_comb begin
    unique case (mode)
      TRIG_LVL_LO:    evt = ~lvl;
      TRIG_EDGE_FALL: evt = prev_q & ~lvl;
      TRIG_LVL_HI:    evt = lvl;
      TRIG_EDGE_RISE: evt = lvl & ~prev_q;
      default:        evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_trig_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 8,
  parameter int unsigned LAYOUT = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              evt,
  output trig_mode_e        mode,
  output logic              pend,
  output logic              en,
  output logic              clr_hit,
  output logic              irq_out
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ctrl_off(LAYOUT));
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(pend_off(LAYOUT));
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(en_off(LAYOUT));

  logic [DATA_W-1:0] ctrl_q;
  logic              pend_q, en_q, out_q;
  logic              hit_ctrl, hit_pend, hit_en;

  assign hit_ctrl = (bus_addr == A_CTRL);
  assign hit_pend = (bus_addr == A_PEND);
  assign hit_en   = (bus_addr == A_EN);
  assign clr_hit  = bus_wr & hit_pend & bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      en_q   <= 1'b0;
    end else if (bus_wr) begin
      if (hit_ctrl) ctrl_q <= bus_wdata;
      if (hit_en)   en_q   <= bus_wdata[0];
    end
  end

  // Set has priority over a same-cycle clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= evt | (pend_q & ~clr_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= pend_q & en_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_ctrl)      bus_rdata = ctrl_q;
      else if (hit_pend) bus_rdata = DATA_W'(pend_q);
      else if (hit_en)   bus_rdata = DATA_W'(en_q);
    end
  end

  assign mode    = trig_mode_e'(ctrl_q[1:0]);
  assign pend    = pend_q;
  assign en      = en_q;
  assign irq_out = out_q;
endmodule

// File: rtl/irq_trig_ctrl.sv
module irq_trig_ctrl
  import irq_trig_pkg::*;
#(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 8,
  parameter int unsigned LAYOUT      = 0,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_in,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_out
);
  logic       sync_lvl, evt, pend, en, clr_hit;
  trig_mode_e mode;

  irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(irq_in), .dout(sync_lvl)
  );

  irq_trig_detect u_detect (
    .clk(clk), .rst_n(rst_n), .lvl(sync_lvl), .mode(mode), .evt(evt)
  );

  irq_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAYOUT(LAYOUT)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .evt(evt), .mode(mode), .pend(pend), .en(en),
    .clr_hit(clr_hit), .irq_out(irq_out)
  );
endmodule

// File: rtl/irq_trig_ctrl_chk.sv
module irq_trig_ctrl_chk
  import irq_trig_pkg::*;
#(
  parameter int          DATA_W = 32,
  parameter int          ADDR_W = 8,
  parameter int unsigned LAYOUT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_rd,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic              sync_lvl,
  input logic              evt,
  input trig_mode_e        mode,
  input logic              pend,
  input logic              en,
  input logic              clr_hit
);
  logic mapped, lvl_mode, lvl_active;
  assign mapped = (bus_addr == ADDR_W'(ctrl_off(LAYOUT))) ||
                  (bus_addr == ADDR_W'(pend_off(LAYOUT))) ||
                  (bus_addr == ADDR_W'(en_off(LAYOUT)));
  assign lvl_mode   = !is_edge(mode);
  assign lvl_active = (mode == TRIG_LVL_HI) ? sync_lvl : !sync_lvl;

  p_edge_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_edge(mode) && evt) |=> pend);

  p_lvl_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && lvl_active) |=> pend);

  p_lvl_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_mode && !lvl_active && clr_hit) |=> !pend);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !clr_hit) |=> pend);

  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !irq_out);

  p_fire_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && en) |=> irq_out);

  p_unmapped_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !mapped) |-> (bus_rdata == '0));

  p_reset_r9: assert property (@(posedge clk)
    $rose(rst_n) |-> (!irq_out && !pend && !en));
endmodule

bind irq_trig_ctrl irq_trig_ctrl_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LAYOUT(LAYOUT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .sync_lvl(sync_lvl),
  .evt(evt), .mode(mode), .pend(pend), .en(en), .clr_hit(clr_hit)
);

// File: tb/test_irq_trig_ctrl.sv
module test_irq_trig_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        irq_in = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  logic [7:0]  l_addr  [1:2];
  logic        l_wr    [1:2];
  logic        l_rd    [1:2];
  logic [31:0] l_wdata [1:2];
  logic [31:0] l_rdata [1:2];
  logic        l_out   [1:2];

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_trig_ctrl #(.LAYOUT(0)) i_irq_trig_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out));

  irq_trig_ctrl #(.LAYOUT(1)) i_irq_trig_ctrl_l1 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(l_addr[1]),
    .bus_wr(l_wr[1]), .bus_wdata(l_wdata[1]), .bus_rd(l_rd[1]),
    .bus_rdata(l_rdata[1]), .irq_out(l_out[1]));

  irq_trig_ctrl #(.LAYOUT(2)) i_irq_trig_ctrl_l2 (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(l_addr[2]),
    .bus_wr(l_wr[2]), .bus_wdata(l_wdata[2]), .bus_rd(l_rd[2]),
    .bus_rdata(l_rdata[2]), .irq_out(l_out[2]));

  // Reference model of layout 0, built from the requirements.
  logic        m_s1, m_s2, m_prev, m_pend, m_en, m_out;
  logic [31:0] m_ctrl;

  function automatic logic evt_f(input logic [1:0] md, input logic cur, input logic old);
    case (md)
      2'd0: evt_f = !cur;
      2'd1: evt_f = old && !cur;
      2'd2: evt_f = cur;
      default: evt_f = cur && !old;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h00: exp_rd = m_ctrl;
      8'h04: exp_rd = {31'd0, m_pend};
      8'h08: exp_rd = {31'd0, m_en};
      default: exp_rd = 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_pend <= 0;
      m_en <= 0; m_out <= 0; m_ctrl <= '0;
    end else begin
      m_s1 <= irq_in; m_s2 <= m_s1; m_prev <= m_s2;
      m_pend <= evt_f(m_ctrl[1:0], m_s2, m_prev) |
                (m_pend & !(bus_wr && bus_addr == 8'h04 && bus_wdata[0]));
      m_out <= m_pend & m_en;
      if (bus_wr && bus_addr == 8'h00) m_ctrl <= bus_wdata;
      if (bus_wr && bus_addr == 8'h08) m_en <= bus_wdata[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %0h exp %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(tag, bus_rdata, exp_rd(a));
    bus_rd = 1'b0;
  endtask

  task automatic rd_lit(input string tag, input logic [7:0] a, input logic [31:0] e);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(tag, bus_rdata, e);
    bus_rd = 1'b0;
  endtask

  task automatic lwr(input int k, input logic [7:0] a, input logic [31:0] d);
    l_addr[k] = a; l_wdata[k] = d; l_wr[k] = 1'b1;
    tick();
    l_wr[k] = 1'b0;
  endtask

  task automatic lrd(input string tag, input int k, input logic [7:0] a, input logic [31:0] e);
    l_addr[k] = a; l_rd[k] = 1'b1;
    #1;
    chk(tag, l_rdata[k], e);
    l_rd[k] = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] pick [6] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h34, 8'hFC};
    int unsigned seed;
    seed = 32'h1234_5678;
    void'($urandom(seed));
    for (int k = 1; k <= 2; k++) begin
      l_addr[k] = '0; l_wr[k] = 0; l_rd[k] = 0; l_wdata[k] = '0;
    end

    // R9: state held at zero during reset
    tick(2);
    chk("R9 irq_out in reset", irq_out, 0);
    rd_lit("R9 ctrl in reset", 8'h00, 0);
    rd_lit("R9 pending in reset", 8'h04, 0);
    rst_n = 1'b1;
    tick(4);

    // R1: default mode 0 is level-low; init sequence
    rd_lit("R1 default mode", 8'h00, 0);
    rd_lit("R1 low level latched pending", 8'h04, 1);
    wr(8'h08, 0);
    wr(8'h04, 1);
    rd_lit("R1 init clears pending", 8'h04, 0);

    // R2: full control word kept
    wr(8'h00, 32'hA5A5_5A5B);
    rd_lit("R2 ctrl readback", 8'h00, 32'hA5A5_5A5B);

    // R10 latency, rising edge mode (mode 3)
    irq_in = 0; tick(4);
    wr(8'h04, 1);
    irq_in = 1; tick(2);
    rd_lit("R10 not yet pending after two edges", 8'h04, 0);
    tick();
    rd_lit("R10 pending after third edge", 8'h04, 1);

    // R5: write 0 has no effect; R3 stickiness across falling step
    wr(8'h04, 32'hFFFF_FFFE);
    irq_in = 0; tick(4);
    rd_lit("R5 zero write keeps pending / R3 sticky", 8'h04, 1);
    wr(8'h04, 1);
    rd_lit("R5 clear", 8'h04, 0);

    // R3 set wins over clear
    irq_in = 1; tick(2);
    wr(8'h04, 1);
    rd_lit("R3 set wins over clear", 8'h04, 1);

    // R6 masked, then enabled
    tick(2);
    chk("R6 masked output", irq_out, 0);
    wr(8'h08, 1);
    chk("R6 output one cycle after enable", irq_out, 0);
    tick();
    chk("R6 output asserted", irq_out, 1);
    wr(8'h08, 0);
    tick();
    chk("R6 output drops after mask", irq_out, 0);
    rd_lit("R6 pending kept while masked", 8'h04, 1);

    // R4 level-high: clear ineffective while active
    wr(8'h00, 2);
    tick(3);
    wr(8'h04, 1);
    rd_lit("R4 clear ignored while level active", 8'h04, 1);
    irq_in = 0; tick(3);
    wr(8'h04, 1);
    rd_lit("R4 clear after level inactive", 8'h04, 0);

    // R1 falling-edge mode
    wr(8'h00, 1);
    irq_in = 1; tick(4);
    rd_lit("R1 falling mode ignores rise", 8'h04, 0);
    irq_in = 0; tick(3);
    rd_lit("R1 falling mode catches fall", 8'h04, 1);

    // R8 unmapped
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h34, 32'hFFFF_FFFF);
    rd_lit("R8 unmapped 0x0C", 8'h0C, 0);
    rd_lit("R8 unmapped write left ctrl", 8'h00, 1);
    rd_lit("R8 unmapped write left enable", 8'h08, 0);

    // R7 layouts 1 and 2: rising mode, edge pending, enable 0
    lwr(1, 8'h00, 3); lwr(2, 8'h00, 3);
    irq_in = 0; tick(4);
    lwr(1, 8'h04, 1); lwr(2, 8'h08, 1);
    irq_in = 1; tick(4);
    lrd("R7 L1 pending at 0x04", 1, 8'h04, 1);
    lrd("R7 L1 enable at 0x34", 1, 8'h34, 0);
    lrd("R7 L1 0x08 unmapped", 1, 8'h08, 0);
    lrd("R7 L2 enable at 0x04", 2, 8'h04, 0);
    lrd("R7 L2 pending at 0x08", 2, 8'h08, 1);
    lwr(1, 8'h34, 1); lwr(2, 8'h04, 1);
    tick();
    chk("R7 L1 output via enable at 0x34", l_out[1], 1);
    chk("R7 L2 output via enable at 0x04", l_out[2], 1);
    lrd("R7 L2 enable readback", 2, 8'h04, 1);

    // Random traffic against the reference model
    for (int n = 0; n < 600; n++) begin
      int op;
      op = $urandom_range(0, 3);
      if ($urandom_range(0, 3) == 0) irq_in = ~irq_in;
      if (op == 0) begin
        logic [31:0] d;
        d = $urandom();
        if (pick[$urandom_range(0, 5)] == 8'h00) d[31:2] = d[31:2];
        wr(pick[$urandom_range(0, 5)], d);
      end else if (op == 1) begin
        logic [7:0] a;
        a = pick[$urandom_range(0, 5)];
        rd_chk((a == 8'h0C || a == 8'h34 || a == 8'hFC) ? "R8 random read" : "R5 R2 random read", a);
        tick();
      end else begin
        tick();
      end
      chk("R6 random irq_out", irq_out, m_out);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule